// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block sits on the device side of a single data rate SDRAM. On every rising clock edge it looks at the chip select, row strobe, column strobe, write enable and clock enable lines and sorts the sample into one of eight commands. Each command leaves the block as a one-cycle pulse on its own output, one clock after the edge that sampled it.

The block also holds the mode register. A mode register set command with a legal value on the low address bits loads it. The stored setting drives four outputs for the datapath that follows: the CAS latency, the burst ordering, the burst length in beats and the write burst policy. A request with a reserved or forbidden combination does not change the register. It raises a one-cycle error flag.

A parameter sets the column address width, and with it the length of a full-page burst. A second parameter can remove full-page support altogether.

Top module: `sdram_cmd_mode_dec`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. All outputs are registered and reflect the sample one cycle after the edge that took it.
- R2: When cke is high and cs_n is high, the command is NOP, whatever the levels on ras_n, cas_n and we_n.
- R3: When cke is high and cs_n is low, exactly one pulse is raised. With {ras_n,cas_n,we_n}: 111 gives NOP, 011 gives ACTIVE, 101 gives READ, 100 gives WRITE, 010 gives PRECHARGE, 001 gives AUTO REFRESH, 000 gives MODE SET and 110 gives BURST STOP.
- R4: When cke is sampled low, no command pulse is raised and the mode register is not written, even if a mode set encoding is present.
- R5: A legal mode set loads these fields: addr[2:0] is the burst length code, addr[3] is the ordering (1 = interleaved), addr[6:4] is the CAS latency code and addr[9] is the write policy (1 = single-location writes). Address bits above 9 are ignored.
- R6: Only CAS latency codes 010 (latency 2) and 011 (latency 3) are accepted. The cas_lat output only ever shows 2 or 3.
- R7: The burst length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. Code 111 gives a full page of 2^COL_BITS beats when FULL_PAGE_EN is set. Codes 100, 101 and 110 are rejected.
- R8: A full-page length combined with interleaved ordering is rejected. A full-page burst therefore always uses sequential ordering.
- R9: A mode set with addr[8:7] not equal to 00 is rejected.
- R10: A rejected mode set raises mode_err for exactly one cycle, together with the MODE SET pulse, and leaves every mode output unchanged.
- R11: After reset, the command pulses and mode_err are low, cas_lat is 3, ordering is sequential, burst_len is 1 and write_single is 0.
- R12: The mode outputs change only in the cycle after a legal mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block samples on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row address strobe, active low |
| cas_n | input | 1 | Column address strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low suspends command decoding |
| addr | input | ADDR_W | Address bus; bits 9:0 carry the mode value |
| cmd_nop | output | 1 | NOP pulse |
| cmd_act | output | 1 | ACTIVE pulse |
| cmd_rd | output | 1 | READ pulse |
| cmd_wr | output | 1 | WRITE pulse |
| cmd_pre | output | 1 | PRECHARGE pulse |
| cmd_ref | output | 1 | AUTO REFRESH pulse |
| cmd_mrs | output | 1 | MODE SET pulse |
| cmd_bst | output | 1 | BURST STOP pulse |
| mode_err | output | 1 | One-cycle flag for a rejected mode value |
| cas_lat | output | 2 | Current CAS latency, 2 or 3 |
| burst_interleave | output | 1 | 1 = interleaved ordering, 0 = sequential |
| burst_len | output | COL_BITS+1 | Burst length in beats |
| write_single | output | 1 | 1 = single-location writes, 0 = burst writes |

## Verification
On every cycle the assertions check the following:
- A sampled high cke leads to exactly one pulse, and a low cke leads to none.
- A deselected chip yields NOP.
- mode_err only ever comes with a MODE SET pulse.
- The mode outputs hold still unless a legal mode set has arrived.
- The latency shown is always 2 or 3, and a full-page burst is never interleaved.

Whether a given legal value lands in the correct fields can only be shown by the bench's scenarios. The same goes for each reserved code being turned away, and for upper address bits and mode sets under low cke or high chip select having no effect.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

   localparam int CMD_N   = 8;
   localparam int CMD_NOP = 0;
   localparam int CMD_ACT = 1;
   localparam int CMD_RD  = 2;
   localparam int CMD_WR  = 3;
   localparam int CMD_PRE = 4;
   localparam int CMD_REF = 5;
   localparam int CMD_MRS = 6;
   localparam int CMD_BST = 7;

   localparam int MODE_BITS = 10;

   typedef struct packed {
      logic [1:0] cas_lat;
      logic       interleave;
      logic [2:0] bl_code;
      logic       single_wr;
   } mode_t;

   localparam mode_t MODE_RESET = '{cas_lat: 2'd3, interleave: 1'b0,
                                    bl_code: 3'b000, single_wr: 1'b0};

   function automatic logic [CMD_N-1:0] cmd_onehot(input logic cs_n,
                                                   input logic ras_n,
                                                   input logic cas_n,
                                                   input logic we_n);
      logic [CMD_N-1:0] v;
      v = '0;
      if (cs_n) begin
         v[CMD_NOP] = 1'b1;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: v[CMD_NOP] = 1'b1;
            3'b011: v[CMD_ACT] = 1'b1;
            3'b101: v[CMD_RD]  = 1'b1;
            3'b100: v[CMD_WR]  = 1'b1;
            3'b010: v[CMD_PRE] = 1'b1;
            3'b001: v[CMD_REF] = 1'b1;
            3'b000: v[CMD_MRS] = 1'b1;
            default: v[CMD_BST] = 1'b1;
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
   import sdram_dec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             cke,
   output logic [CMD_N-1:0] hot_now,
   output logic [CMD_N-1:0] cmd_q
);

   // A low clock enable suspends decoding entirely.
   always_comb begin
      hot_now = cke ? cmd_onehot(cs_n, ras_n, cas_n, we_n) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= hot_now;
   end

endmodule

// File: rtl/sdram_mode_check.sv
module sdram_mode_check
   import sdram_dec_pkg::*;
#(
   parameter bit FULL_PAGE_EN = 1'b1
)(
   input  logic [MODE_BITS-1:0] val,
   output logic                 legal,
   output mode_t                nxt
);

   logic bl_short_ok;
   logic bl_page_ok;
   logic cl_ok;
   logic op_ok;

   assign bl_short_ok = (val[2] == 1'b0);
   assign cl_ok       = (val[6:4] == 3'b010) || (val[6:4] == 3'b011);
   assign op_ok       = (val[8:7] == 2'b00);

   generate
      if (FULL_PAGE_EN) begin : g_page
         // full page allows sequential ordering only
         assign bl_page_ok = (val[2:0] == 3'b111) && !val[3];
      end else begin : g_no_page
         assign bl_page_ok = 1'b0;
      end
   endgenerate

   assign legal = (bl_short_ok || bl_page_ok) && cl_ok && op_ok;

   always_comb begin
      nxt.cas_lat    = {1'b1, val[4]};
      nxt.interleave = val[3];
      nxt.bl_code    = val[2:0];
      nxt.single_wr  = val[9];
   end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
   import sdram_dec_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  logic  legal,
   input  mode_t nxt,
   output mode_t mode_q,
   output logic  err_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else begin
         err_q <= wr_en && !legal;
         if (wr_en && legal) mode_q <= nxt;
      end
   end

endmodule

// File: rtl/sdram_cmd_mode_dec.sv
module sdram_cmd_mode_dec
   import sdram_dec_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int COL_BITS     = 10,
   parameter bit FULL_PAGE_EN = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                cke,
   input  logic [ADDR_W-1:0]   addr,
   output logic                cmd_nop,
   output logic                cmd_act,
   output logic                cmd_rd,
   output logic                cmd_wr,
   output logic                cmd_pre,
   output logic                cmd_ref,
   output logic                cmd_mrs,
   output logic                cmd_bst,
   output logic                mode_err,
   output logic [1:0]          cas_lat,
   output logic                burst_interleave,
   output logic [COL_BITS:0]   burst_len,
   output logic                write_single
);

   localparam int LEN_W = COL_BITS + 1;

   generate
      if (ADDR_W < MODE_BITS) begin : g_bad_addr
         $error("ADDR_W must cover the mode value bits");
      end
      if (COL_BITS < 3 || COL_BITS > 16) begin : g_bad_cols
         $error("COL_BITS must lie between 3 and 16");
      end
      if (ADDR_W > MODE_BITS) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:MODE_BITS];
      end
   endgenerate

   logic [CMD_N-1:0] hot_now;
   logic [CMD_N-1:0] cmd_q;
   logic             legal;
   mode_t            nxt;
   mode_t            mode_q;

   sdram_cmd_classify u_cls (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .cke     (cke),
      .hot_now (hot_now),
      .cmd_q   (cmd_q)
   );

   sdram_mode_check #(.FULL_PAGE_EN(FULL_PAGE_EN)) u_chk_val (
      .val   (addr[MODE_BITS-1:0]),
      .legal (legal),
      .nxt   (nxt)
   );

   sdram_mode_reg u_mreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (hot_now[CMD_MRS]),
      .legal  (legal),
      .nxt    (nxt),
      .mode_q (mode_q),
      .err_q  (mode_err)
   );

   assign cmd_nop = cmd_q[CMD_NOP];
   assign cmd_act = cmd_q[CMD_ACT];
   assign cmd_rd  = cmd_q[CMD_RD];
   assign cmd_wr  = cmd_q[CMD_WR];
   assign cmd_pre = cmd_q[CMD_PRE];
   assign cmd_ref = cmd_q[CMD_REF];
   assign cmd_mrs = cmd_q[CMD_MRS];
   assign cmd_bst = cmd_q[CMD_BST];

   assign cas_lat          = mode_q.cas_lat;
   assign burst_interleave = mode_q.interleave;
   assign write_single     = mode_q.single_wr;

   always_comb begin
      unique case (mode_q.bl_code)
         3'b000:  burst_len = LEN_W'(1);
         3'b001:  burst_len = LEN_W'(2);
         3'b010:  burst_len = LEN_W'(4);
         3'b011:  burst_len = LEN_W'(8);
         default: burst_len = LEN_W'(1) << COL_BITS;
      endcase
   end

endmodule

// File: rtl/sdram_cmd_mode_dec_chk.sv
module sdram_cmd_mode_dec_chk #(
   parameter int COL_BITS = 10
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              cke,
   input logic [7:0]        cmds,
   input logic              cmd_nop,
   input logic              cmd_mrs,
   input logic              mode_err,
   input logic [1:0]        cas_lat,
   input logic              burst_interleave,
   input logic [COL_BITS:0] burst_len,
   input logic              write_single
);

   logic [COL_BITS+4:0] mode_vec;
   assign mode_vec = {cas_lat, burst_interleave, burst_len, write_single};

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> $countones(cmds) == 1); // R3
   AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> cmds == 8'd0); // R4
   AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cke) |=> cmd_nop); // R2
   AST_ERR_WITH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> cmd_mrs); // R10
   AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> $stable(mode_vec)); // R10
   AST_MODE_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_mrs |-> $stable(mode_vec)); // R12
   AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cas_lat == 2'd2 || cas_lat == 2'd3); // R6
   AST_PAGE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_len == {1'b1, {COL_BITS{1'b0}}}) |-> !burst_interleave); // R8

endmodule

bind sdram_cmd_mode_dec sdram_cmd_mode_dec_chk #(.COL_BITS(COL_BITS)) u_sva (
   .clk              (clk),
   .rst_n            (rst_n),
   .cs_n             (cs_n),
   .cke              (cke),
   .cmds             ({cmd_bst, cmd_mrs, cmd_ref, cmd_pre, cmd_wr, cmd_rd, cmd_act, cmd_nop}),
   .cmd_nop          (cmd_nop),
   .cmd_mrs          (cmd_mrs),
   .mode_err         (mode_err),
   .cas_lat          (cas_lat),
   .burst_interleave (burst_interleave),
   .burst_len        (burst_len),
   .write_single     (write_single)
);

// File: tb/sdram_cmd_mode_dec_tb.sv
`timescale 1ns/1ps
module sdram_cmd_mode_dec_tb;

   localparam int AW = 12;
   localparam int CB = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [AW-1:0] addr = '0;
   logic cmd_nop, cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst;
   logic mode_err, burst_interleave, write_single;
   logic [1:0] cas_lat;
   logic [CB:0] burst_len;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // expected state
   logic [1:0]  m_cl = 2'd3;
   logic        m_il = 1'b0;
   logic [CB:0] m_len = 1;
   logic        m_sw = 1'b0;

   always #2.5 clk = ~clk;

   sdram_cmd_mode_dec #(.ADDR_W(AW), .COL_BITS(CB)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .cke(cke), .addr(addr),
      .cmd_nop(cmd_nop), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
      .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .cmd_bst(cmd_bst),
      .mode_err(mode_err), .cas_lat(cas_lat), .burst_interleave(burst_interleave),
      .burst_len(burst_len), .write_single(write_single)
   );

   // {bst,mrs,ref,pre,wr,rd,act,nop} per R2/R3/R4
   function automatic logic [7:0] exp_cmd(logic c, logic r, logic ca, logic w, logic k);
      if (!k) return 8'h00;
      if (c)  return 8'h01;
      case ({r, ca, w})
         3'b111: return 8'h01;
         3'b011: return 8'h02;
         3'b101: return 8'h04;
         3'b100: return 8'h08;
         3'b010: return 8'h10;
         3'b001: return 8'h20;
         3'b000: return 8'h40;
         default: return 8'h80;
      endcase
   endfunction

   // R6 R7 R8 R9
   function automatic bit exp_legal(logic [AW-1:0] a);
      bit ok_bl, ok_cl, ok_op;
      ok_bl = (a[2:0] <= 3'd3) || (a[2:0] == 3'd7 && !a[3]);
      ok_cl = (a[6:4] == 3'd2) || (a[6:4] == 3'd3);
      ok_op = (a[8:7] == 2'd0);
      return ok_bl && ok_cl && ok_op;
   endfunction

   function automatic logic [CB:0] exp_len(logic [2:0] code);
      return (code <= 3'd3) ? (CB+1)'(1) << code : (CB+1)'(1) << CB;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req, logic [7:0] e_cmd, logic e_err);
      chk(req, {cmd_bst, cmd_mrs, cmd_ref, cmd_pre, cmd_wr, cmd_rd, cmd_act, cmd_nop}, e_cmd, "cmd");
      chk(req, mode_err, e_err, "mode_err");
      chk(req, cas_lat, m_cl, "cas_lat");
      chk(req, burst_interleave, m_il, "interleave");
      chk(req, burst_len, m_len, "burst_len");
      chk(req, write_single, m_sw, "write_single");
   endtask

   // drive at negedge, model at posedge, compare 1 ns after posedge (R1)
   task automatic step(logic c, logic r, logic ca, logic w, logic k,
                       logic [AW-1:0] a, string req);
      logic [7:0] e;
      logic       e_err;
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; addr = a;
      @(posedge clk);
      e = exp_cmd(c, r, ca, w, k);
      e_err = e[6] && !exp_legal(a);
      if (e[6] && exp_legal(a)) begin
         m_cl  = {1'b1, a[4]};
         m_il  = a[3];
         m_len = exp_len(a[2:0]);
         m_sw  = a[9];
      end
      #1;
      check_all(req, e, e_err);
   endtask

   task automatic mrs(logic [AW-1:0] a, string req);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, req);
   endtask

   initial begin
      void'($urandom(32'h5D1A));
      repeat (3) @(posedge clk);
      #1;
      check_all("R11", 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_all("R11", 8'h00, 1'b0);

      // R3 every encoding with chip selected
      for (int i = 0; i < 8; i++)
         step(1'b0, i[2], i[1], i[0], 1'b1, '0, "R3");
      // R2 deselect with any strobes
      for (int i = 0; i < 8; i++)
         step(1'b1, i[2], i[1], i[0], 1'b1, '0, "R2");
      // R5 legal loads: CL2, BL4, interleave, single write
      mrs(12'b00_1_00_010_1_010, "R5");
      // R5 upper bits ignored, CL3 BL8 sequential
      mrs(12'b11_0_00_011_0_011, "R5");
      // R6 CL codes rejected
      mrs(12'b00_0_00_001_0_001, "R6");
      mrs(12'b00_0_00_100_0_001, "R6");
      mrs(12'b00_0_00_000_0_001, "R6");
      // R7 reserved BL codes and full page
      mrs(12'b00_0_00_010_0_100, "R7");
      mrs(12'b00_0_00_010_0_101, "R7");
      mrs(12'b00_0_00_010_0_110, "R7");
      mrs(12'b00_0_00_010_0_111, "R7");
      mrs(12'b00_0_00_011_0_000, "R7");
      mrs(12'b00_0_00_011_0_001, "R7");
      // R8 full page with interleave rejected
      mrs(12'b00_0_00_010_1_111, "R8");
      // R9 operating mode bits
      mrs(12'b00_0_01_010_0_010, "R9");
      mrs(12'b00_0_10_010_0_010, "R9");
      // R10 back-to-back rejects then a legal one
      mrs(12'b00_0_00_111_0_000, "R10");
      mrs(12'b00_1_00_011_0_010, "R10");
      // R4 suspended mode set and commands ignored
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'b00_0_00_010_1_001, "R4");
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R4");
      // R12 mode set encoding with chip deselected leaves mode
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'b00_0_00_010_1_001, "R12");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] a;
         logic [2:0] pick;
         a = AW'($urandom);
         if ($urandom_range(0, 1) == 0) begin
            pick = 3'($urandom_range(0, 5));
            a[2:0] = (pick == 3'd5) ? 3'd7 : (pick == 3'd4 ? 3'($urandom) : pick);
            a[6:4] = 3'($urandom_range(2, 3));
            a[8:7] = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
         end
         if ($urandom_range(0, 2) == 0)
            step(1'b0, 1'b0, 1'b0, 1'b0, ($urandom_range(0, 9) != 0), a, "R12");
         else
            step(($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom_range(0, 6) != 0), a, "R3");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule